// File: doc/BRIEF.md
# Maskable Interrupt Status Controller

This block collects sixteen interrupt request lines into a sticky pending register. Every source bit that is high in a cycle latches its pending bit, and software acknowledges a pending bit by writing a one to it. A second register holds enable bits. The single processor interrupt line is raised whenever a bit is both pending and enabled. Software reaches both registers through a plain register port with write enable, read enable, an 8-bit offset, 32-bit data and a read-valid strobe.

If a source assertion and an acknowledge land on the same bit in the same cycle, the assertion takes precedence and the bit stays pending. Each cycle in which the pending or enable register changes value produces a one-cycle trace event. The event carries argument words and a flags word. These say whether the change came from a source or from a register write, whether an acknowledge really cleared something, and what the registers hold after the update.

Top module: `irq_status_ctrl`

## Requirements
- R1: A source bit that is high at a clock edge sets its pending bit, and the bit stays set after the source falls.
- R2: A write to offset 0x00 clears each pending bit whose data bit is 1, and leaves the bits whose data bit is 0 untouched.
- R3: A write to offset 0x10 loads the enable register from data bits 15:0, and a read of 0x10 returns that value.
- R4: `cpu_irq` is high exactly when some bit is both pending and enabled. A disabled source still latches into the pending register.
- R5: Setting the enable bit of a bit that is already pending raises `cpu_irq` with no new source activity.
- R6: When an acknowledge and a source assertion hit the same bit in the same cycle, the bit stays pending. A later acknowledge with no coincident assertion clears it.
- R7: Each clock edge that changes the pending or enable register produces `trc_valid` high for exactly the following cycle, with `trc_kind` = 4'h2. No event is produced at an edge that changes neither register.
- R8: `trc_flags` bit 0 is 1 when the change came with a write to a mapped offset, and 0 when it came from sources alone.
- R9: `trc_arg3` is 1 only when an acknowledge actually cleared at least one pending bit, and 0 otherwise. `trc_arg0` is the enable register after the update. `trc_arg1` and `trc_arg2` are both the pending register after the update, including any bit set again in that same cycle.
- R10: While `rst_n` is low and after it is released, both registers are zero, `cpu_irq` is low and `trc_valid` is low.
- R11: A read returns the addressed register in bits 15:0 with bits 31:16 zero, and `rvalid` pulses in the cycle after `rd_en`. Reads of unmapped offsets return zero, and writes to unmapped offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Register offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid while rvalid is high |
| rvalid | output | 1 | Read data valid, one cycle after rd_en |
| src | input | 16 | Interrupt source levels |
| cpu_irq | output | 1 | Processor interrupt line |
| trc_valid | output | 1 | Trace event strobe |
| trc_kind | output | 4 | Trace event kind (4'h2 = interrupt) |
| trc_arg0 | output | 32 | Enable register after the update |
| trc_arg1 | output | 32 | Pending register after the update |
| trc_arg2 | output | 32 | Pending register after the update |
| trc_arg3 | output | 32 | 1 when an acknowledge cleared a bit |
| trc_flags | output | 32 | Bit 0: caused by a register write |

## Verification
The assertions assume that `src`, `wr_en`, `rd_en`, `addr` and `wdata` carry known values at every clock edge after reset is released. They also assume that a read and a write are never issued in the same cycle, so the read data always reflects settled register state. The bench drives every input on the falling edge and parks them at zero between operations. Every operation it issues is a single read, a single write, a source pulse, or one deliberately combined acknowledge-plus-source cycle.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  typedef enum logic [3:0] {
    TRC_NONE = 4'h0,
    TRC_IRQ  = 4'h2
  } trc_kind_e;

  localparam logic [7:0] OFS_PEND = 8'h00;
  localparam logic [7:0] OFS_ENAB = 8'h10;
endpackage

// File: rtl/irqc_regs.sv
module irqc_regs #(
  parameter int NSRC = 16,
  parameter int AW   = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [AW-1:0]   addr,
  input  logic [NSRC-1:0] wbits,
  input  logic [NSRC-1:0] src,
  output logic [NSRC-1:0] pend_q,
  output logic [NSRC-1:0] enab_q,
  output logic [NSRC-1:0] pend_d,
  output logic [NSRC-1:0] enab_d,
  output logic            reg_write,
  output logic [NSRC-1:0] ack_hit
);
  import irqc_pkg::*;

  // set wins over clear: the clear mask is applied before the OR of new sets
  function automatic logic [NSRC-1:0] pend_next(input logic [NSRC-1:0] cur,
                                                input logic [NSRC-1:0] set,
                                                input logic [NSRC-1:0] clr);
    return (cur & ~clr) | set;
  endfunction

  logic            pend_sel, enab_sel;
  logic [NSRC-1:0] clr_vec;

  always_comb begin
    pend_sel  = wr_en && (addr == AW'(OFS_PEND));
    enab_sel  = wr_en && (addr == AW'(OFS_ENAB));
    reg_write = pend_sel || enab_sel;
    clr_vec   = pend_sel ? wbits : '0;
    pend_d    = pend_next(pend_q, src, clr_vec);
    enab_d    = enab_sel ? wbits : enab_q;
    ack_hit   = pend_q & clr_vec & ~src;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      enab_q <= '0;
    end else begin
      pend_q <= pend_d;
      enab_q <= enab_d;
    end
  end

  p_sticky_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(pend_q) & ~$past(clr_vec) & ~pend_q) == '0));

  p_source_latch_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (src != '0) |=> ((pend_q & $past(src)) == $past(src)));

  p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((src & clr_vec) != '0) |=> ((pend_q & $past(src & clr_vec)) == $past(src & clr_vec)));

  p_enab_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !enab_sel |=> $stable(enab_q));
endmodule

// File: rtl/irqc_trace.sv
module irqc_trace #(
  parameter int NSRC = 16,
  parameter int ARGW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] pend_q,
  input  logic [NSRC-1:0] enab_q,
  input  logic [NSRC-1:0] pend_d,
  input  logic [NSRC-1:0] enab_d,
  input  logic            reg_write,
  input  logic [NSRC-1:0] ack_hit,
  output logic            trc_valid,
  output logic [3:0]      trc_kind,
  output logic [ARGW-1:0] trc_arg0,
  output logic [ARGW-1:0] trc_arg1,
  output logic [ARGW-1:0] trc_arg2,
  output logic [ARGW-1:0] trc_arg3,
  output logic [ARGW-1:0] trc_flags
);
  import irqc_pkg::*;

  function automatic logic [ARGW-1:0] widen(input logic [NSRC-1:0] v);
    return {{(ARGW-NSRC){1'b0}}, v};
  endfunction

  logic change;
  assign change = (pend_d != pend_q) || (enab_d != enab_q);

  always_ff @(posedge clk) begin
    if (!rst_n || !change) begin
      trc_valid <= 1'b0;
      trc_kind  <= TRC_NONE;
      trc_arg0  <= '0;
      trc_arg1  <= '0;
      trc_arg2  <= '0;
      trc_arg3  <= '0;
      trc_flags <= '0;
    end else begin
      trc_valid <= 1'b1;
      trc_kind  <= TRC_IRQ;
      trc_arg0  <= widen(enab_d);
      trc_arg1  <= widen(pend_d);
      trc_arg2  <= widen(pend_d);
      trc_arg3  <= ARGW'(ack_hit != '0);
      trc_flags <= ARGW'(reg_write);
    end
  end

  p_event_on_change_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_q != $past(pend_q)) || (enab_q != $past(enab_q))) |-> trc_valid);

  p_event_needs_change_r7: assert property (@(posedge clk) disable iff (!rst_n)
    trc_valid |-> ((pend_q != $past(pend_q)) || (enab_q != $past(enab_q))));

  p_args_post_r9: assert property (@(posedge clk) disable iff (!rst_n)
    trc_valid |-> (trc_arg1 == widen(pend_q)) && (trc_arg0 == widen(enab_q)));

  p_ack_is_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (trc_valid && trc_arg3[0]) |-> trc_flags[0]);
endmodule

// File: rtl/irqc_rdport.sv
module irqc_rdport #(
  parameter int NSRC = 16,
  parameter int AW   = 8,
  parameter int DW   = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rd_en,
  input  logic [AW-1:0]   addr,
  input  logic [NSRC-1:0] pend_q,
  input  logic [NSRC-1:0] enab_q,
  output logic [DW-1:0]   rdata,
  output logic            rvalid
);
  import irqc_pkg::*;

  function automatic logic [DW-1:0] pick(input logic [AW-1:0] a,
                                         input logic [NSRC-1:0] p,
                                         input logic [NSRC-1:0] e);
    if (a == AW'(OFS_PEND)) return {{(DW-NSRC){1'b0}}, p};
    if (a == AW'(OFS_ENAB)) return {{(DW-NSRC){1'b0}}, e};
    return '0;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd_en;
      rdata  <= rd_en ? pick(addr, pend_q, enab_q) : '0;
    end
  end

  p_rvalid_follows_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rvalid);

  p_rvalid_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rvalid);

  p_rdata_hi_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |-> (rdata[DW-1:NSRC] == '0));
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl #(
  parameter int NSRC = 16,
  parameter int AW   = 8,
  parameter int DW   = 32,
  parameter int ARGW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic            rd_en,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   rdata,
  output logic            rvalid,
  input  logic [NSRC-1:0] src,
  output logic            cpu_irq,
  output logic            trc_valid,
  output logic [3:0]      trc_kind,
  output logic [ARGW-1:0] trc_arg0,
  output logic [ARGW-1:0] trc_arg1,
  output logic [ARGW-1:0] trc_arg2,
  output logic [ARGW-1:0] trc_arg3,
  output logic [ARGW-1:0] trc_flags
);
  function automatic logic irq_of(input logic [NSRC-1:0] p, input logic [NSRC-1:0] e);
    return |(p & e);
  endfunction

  logic [NSRC-1:0] pend_q, enab_q, pend_d, enab_d, ack_hit;
  logic            reg_write;
  logic            unused_wdata_hi;

  assign unused_wdata_hi = ^wdata[DW-1:NSRC];

  irqc_regs #(.NSRC(NSRC), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wbits(wdata[NSRC-1:0]), .src(src),
    .pend_q(pend_q), .enab_q(enab_q), .pend_d(pend_d), .enab_d(enab_d),
    .reg_write(reg_write), .ack_hit(ack_hit)
  );

  irqc_trace #(.NSRC(NSRC), .ARGW(ARGW)) u_trace (
    .clk(clk), .rst_n(rst_n),
    .pend_q(pend_q), .enab_q(enab_q), .pend_d(pend_d), .enab_d(enab_d),
    .reg_write(reg_write), .ack_hit(ack_hit),
    .trc_valid(trc_valid), .trc_kind(trc_kind),
    .trc_arg0(trc_arg0), .trc_arg1(trc_arg1), .trc_arg2(trc_arg2),
    .trc_arg3(trc_arg3), .trc_flags(trc_flags)
  );

  irqc_rdport #(.NSRC(NSRC), .AW(AW), .DW(DW)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .addr(addr),
    .pend_q(pend_q), .enab_q(enab_q), .rdata(rdata), .rvalid(rvalid)
  );

  assign cpu_irq = irq_of(pend_q, enab_q);

  p_irq_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(pend_q) && $stable(enab_q)) |-> $stable(cpu_irq));

  p_irq_needs_enable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (enab_q == '0) |-> !cpu_irq);

  p_quiet_after_reset_r10: assert property (@(posedge clk)
    !rst_n |=> (!trc_valid && !rvalid));
endmodule

// File: tb/sim_irq_status_ctrl.sv
`timescale 1ns/1ps
module sim_irq_status_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rvalid;
  logic [15:0] src = '0;
  logic        cpu_irq, trc_valid;
  logic [3:0]  trc_kind;
  logic [31:0] trc_arg0, trc_arg1, trc_arg2, trc_arg3, trc_flags;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  irq_status_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rvalid(rvalid), .src(src), .cpu_irq(cpu_irq),
    .trc_valid(trc_valid), .trc_kind(trc_kind), .trc_arg0(trc_arg0),
    .trc_arg1(trc_arg1), .trc_arg2(trc_arg2), .trc_arg3(trc_arg3),
    .trc_flags(trc_flags)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // single-cycle write; returns at the falling edge after the updating edge
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0; addr = '0; wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; addr = '0;
    check("R11 rvalid", {31'd0, rvalid}, 32'd1);
    d = rdata;
    @(negedge clk);
    check("R11 rvalid one cycle", {31'd0, rvalid}, 32'd0);
  endtask

  task automatic pulse(input logic [15:0] v);
    @(negedge clk); src = v;
    @(negedge clk); src = '0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    check("R10 irq low", {31'd0, cpu_irq}, 32'd0);
    check("R10 no event", {31'd0, trc_valid}, 32'd0);
    rd(8'h00, d); check("R10 pending zero", d, 32'd0);
    rd(8'h10, d); check("R10 enable zero", d, 32'd0);
  endtask

  task automatic t_latch;
    logic [31:0] d;
    wr(8'h10, 32'h0000_000F);
    check("R7 mask event", {31'd0, trc_valid}, 32'd1);
    check("R7 kind", {28'd0, trc_kind}, 32'd2);
    check("R8 write flag", trc_flags, 32'd1);
    check("R9 arg0 enable", trc_arg0, 32'h0000_000F);
    check("R9 arg3 no ack", trc_arg3, 32'd0);
    pulse(16'h0002);
    check("R8 source flag", trc_flags, 32'd0);
    check("R7 source event", {31'd0, trc_valid}, 32'd1);
    check("R9 arg1 status", trc_arg1, 32'h0000_0002);
    check("R4 irq raised", {31'd0, cpu_irq}, 32'd1);
    @(negedge clk);
    check("R7 single cycle", {31'd0, trc_valid}, 32'd0);
    rd(8'h00, d); check("R1 sticky", d, 32'h0000_0002);
  endtask

  task automatic t_clear;
    wr(8'h00, 32'h0000_FFFD);
    check("R2 zero bit kept, no event", {31'd0, trc_valid}, 32'd0);
    check("R2 irq still high", {31'd0, cpu_irq}, 32'd1);
    wr(8'h00, 32'h0000_0002);
    check("R9 ack arg3", trc_arg3, 32'd1);
    check("R9 ack arg1", trc_arg1, 32'd0);
    check("R2 irq dropped", {31'd0, cpu_irq}, 32'd0);
  endtask

  task automatic t_masked;
    logic [31:0] d;
    pulse(16'h0100);
    check("R4 masked irq low", {31'd0, cpu_irq}, 32'd0);
    rd(8'h00, d); check("R4 masked latched", d, 32'h0000_0100);
    wr(8'h10, 32'h0000_010F);
    check("R5 widened irq", {31'd0, cpu_irq}, 32'd1);
    check("R3 arg0 after widen", trc_arg0, 32'h0000_010F);
    wr(8'h00, 32'h0000_0100);
    check("R5 ack irq low", {31'd0, cpu_irq}, 32'd0);
  endtask

  task automatic t_collision;
    logic [31:0] d;
    pulse(16'h000C);
    @(negedge clk); wr_en = 1'b1; addr = 8'h00; wdata = 32'h0000_000C; src = 16'h0004;
    @(negedge clk); wr_en = 1'b0; wdata = '0; src = '0;
    check("R9 partial ack arg3", trc_arg3, 32'd1);
    check("R6 arg1 keeps reset bit", trc_arg1, 32'h0000_0004);
    check("R9 arg2 keeps reset bit", trc_arg2, 32'h0000_0004);
    check("R8 collision flag", trc_flags, 32'd1);
    @(negedge clk); wr_en = 1'b1; addr = 8'h00; wdata = 32'h0000_0004; src = 16'h0004;
    @(negedge clk); wr_en = 1'b0; wdata = '0; src = '0;
    check("R6 pure collision no event", {31'd0, trc_valid}, 32'd0);
    rd(8'h00, d); check("R6 bit still pending", d, 32'h0000_0004);
    wr(8'h00, 32'h0000_0004);
    check("R6 later ack arg3", trc_arg3, 32'd1);
    rd(8'h00, d); check("R6 later ack clears", d, 32'd0);
  endtask

  task automatic t_unmapped;
    logic [31:0] d;
    wr(8'h20, 32'h0000_FFFF);
    check("R11 unmapped write no event", {31'd0, trc_valid}, 32'd0);
    rd(8'h20, d); check("R11 unmapped read zero", d, 32'd0);
    rd(8'h10, d); check("R11 enable untouched", d, 32'h0000_010F);
    wr(8'h10, 32'hFFFF_1234);
    rd(8'h10, d); check("R3 low half only", d, 32'h0000_1234);
  endtask

  initial begin
    #600000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    check("R10 no event in reset", {31'd0, trc_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_latch();
    t_clear();
    t_masked();
    t_collision();
    t_unmapped();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule